// File: doc/BRIEF.md
# Indexed-Colour Pixel Mixer with Cursor Overlay

This block turns a stream of 8-bit colour indices into 24-bit RGB pixels and lays a 64×64 two-bit hardware cursor over them. The raster engine presents one pixel per cycle as a coordinate pair, an index and a valid strobe. The mixer looks the index up in a 256-entry colour table and checks whether the coordinate lies inside the cursor square. If it does, the mixer reads a 2-bit code from the cursor pattern store. A zero code lets the table colour through. Any other code replaces it with one of three dedicated cursor colours.

Two control inputs are sampled alongside each pixel. One turns the whole output black and the other removes the cursor. The cursor position arrives as one packed word. The colour table, the pattern store and the cursor colours are each loaded through a simple write port. The output is a registered RGB word with its own valid flag. Raster timing and frame-buffer fetch belong to neighbouring blocks.

Top module: `cursor_mixer`

## Requirements
- R1: While reset is asserted, and at any time `out_valid` is low, `out_rgb` is zero. After reset the cursor colours are zero.
- R2: A pixel presented with `pix_valid` high at clock edge k produces `out_valid` high after edge k+2, and its colour appears in the same cycle. The block accepts a new pixel on every cycle, and a cycle without `pix_valid` produces a cycle with `out_valid` low two edges later.
- R3: Outside the cursor square, `out_rgb` equals the colour-table entry addressed by `pix_index`, with red in bits 23:16, green in 15:8 and blue in 7:0 as written.
- R4: The cursor origin is cx = `cursor_pos[23:12]` and cy = `cursor_pos[11:0]`. A pixel lies inside the square when cx ≤ x < cx+64 and cy ≤ y < cy+64.
- R5: Inside the square, with dx = x−cx and dy = y−cy, the pattern word at address dy·8 + dx/8 supplies the code from bits [2·(dx mod 8)+1 : 2·(dx mod 8)].
- R6: Code 0 shows the colour-table entry. Codes 1, 2 and 3 show cursor colours 0, 1 and 2, which are written with `cpal_sel` values 0, 1 and 2.
- R7: While `cursor_off` is high, every pixel is treated as outside the square.
- R8: While `force_blank` is high, each valid output pixel is zero and its valid flag is unchanged.
- R9: The window test does not wrap. A cursor near coordinate 4095 covers only pixels up to 4095 and never covers pixels near 0.
- R10: A write to the colour table, the pattern store or a cursor colour affects every pixel presented on a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_x | input | 12 | Pixel column |
| pix_y | input | 12 | Pixel row |
| pix_index | input | 8 | Colour-table index of the pixel |
| cursor_pos | input | 24 | Cursor origin, column in 23:12 and row in 11:0 |
| cursor_off | input | 1 | Hide the cursor |
| force_blank | input | 1 | Force black output |
| pal_we | input | 1 | Colour-table write enable |
| pal_addr | input | 8 | Colour-table write address |
| pal_data | input | 24 | Colour-table write data (RGB) |
| cpal_we | input | 1 | Cursor-colour write enable |
| cpal_sel | input | 2 | Cursor colour 0..2 to write |
| cpal_data | input | 24 | Cursor colour data (RGB) |
| pat_we | input | 1 | Pattern-store write enable |
| pat_addr | input | 9 | Pattern word address |
| pat_data | input | 16 | Pattern word, eight 2-bit codes |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output colour |

## Verification
The first run puts the cursor well away from the scanned row, so the output shows the colour table alone. The next run scans a frame that surrounds the square on all four sides. The pattern store holds a mix of codes, so this run separates the transparent case from each cursor colour and exposes any mistake in the word address or bit slice at the square's edges. The same frame is then repeated with the cursor hidden, then with the output blanked, and then with gaps in the valid strobe, which tests the control gating and the two-cycle alignment. Finally the cursor is placed at the far corner and the scan crosses 4095 into 0, which separates a clipped cursor from a wrapped one. Single writes followed at once by a pixel show when new table contents take effect.

// File: rtl/cmix_pkg.sv
package cmix_pkg;
    // bits per cursor code and per output colour
    localparam int CODE_W = 2;
    localparam int RGB_W  = 24;
    // number of non-transparent cursor colours
    localparam int CPAL_N = (1 << CODE_W) - 1;
    typedef logic [RGB_W-1:0] rgb_t;
endpackage

// File: rtl/cmix_ram.sv
module cmix_ram #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // registered read; a read in the same cycle as a write returns the old word
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/cmix_window.sv
module cmix_window #(
    parameter int COORD_W      = 12,
    parameter int CUR_DIM      = 64,
    parameter int PIX_PER_WORD = 8,
    localparam int DW    = COORD_W + 1,
    localparam int SUB_W = $clog2(PIX_PER_WORD),
    localparam int ROW_W = $clog2(CUR_DIM),
    localparam int COL_W = ROW_W - SUB_W,
    localparam int PAT_AW = ROW_W + COL_W
) (
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [COORD_W-1:0] cx,
    input  logic [COORD_W-1:0] cy,
    input  logic               hide,
    output logic               hit,
    output logic [PAT_AW-1:0]  word,
    output logic [SUB_W-1:0]   sub
);
    logic signed [DW-1:0] dx, dy;
    logic                 in_x, in_y;

    // one extra sign bit keeps offsets left of or above the origin negative
    assign dx = $signed({1'b0, x}) - $signed({1'b0, cx});
    assign dy = $signed({1'b0, y}) - $signed({1'b0, cy});

    assign in_x = !dx[DW-1] && (dx[DW-2:0] < (DW-1)'(CUR_DIM));
    assign in_y = !dy[DW-1] && (dy[DW-2:0] < (DW-1)'(CUR_DIM));
    assign hit  = !hide && in_x && in_y;

    // row-major pattern layout: each row has CUR_DIM/PIX_PER_WORD words
    assign word = {dy[ROW_W-1:0], dx[ROW_W-1:SUB_W]};
    assign sub  = dx[SUB_W-1:0];
endmodule

// File: rtl/cursor_mixer.sv
module cursor_mixer
    import cmix_pkg::*;
#(
    parameter int COORD_W      = 12,
    parameter int IDX_W        = 8,
    parameter int CUR_DIM      = 64,
    parameter int PIX_PER_WORD = 8,
    localparam int SUB_W     = $clog2(PIX_PER_WORD),
    localparam int PAT_WORDS = CUR_DIM * CUR_DIM / PIX_PER_WORD,
    localparam int PAT_AW    = $clog2(PAT_WORDS),
    localparam int WORD_W    = PIX_PER_WORD * CODE_W,
    localparam int PAL_DEPTH = 1 << IDX_W,
    localparam int SEL_W     = $clog2(CPAL_N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_valid,
    input  logic [COORD_W-1:0]   pix_x,
    input  logic [COORD_W-1:0]   pix_y,
    input  logic [IDX_W-1:0]     pix_index,
    input  logic [2*COORD_W-1:0] cursor_pos,
    input  logic                 cursor_off,
    input  logic                 force_blank,
    input  logic                 pal_we,
    input  logic [IDX_W-1:0]     pal_addr,
    input  logic [RGB_W-1:0]     pal_data,
    input  logic                 cpal_we,
    input  logic [SEL_W-1:0]     cpal_sel,
    input  logic [RGB_W-1:0]     cpal_data,
    input  logic                 pat_we,
    input  logic [PAT_AW-1:0]    pat_addr,
    input  logic [WORD_W-1:0]    pat_data,
    output logic                 out_valid,
    output logic [RGB_W-1:0]     out_rgb
);
    typedef struct packed {
        logic                        s1_valid;
        logic                        s1_hit;
        logic [SUB_W-1:0]            s1_sub;
        logic                        s1_blank;
        logic [CPAL_N-1:0][RGB_W-1:0] cpal;
        logic                        o_valid;
        rgb_t                        o_rgb;
    } state_t;

    state_t st_d, st_q;

    logic              win_hit;
    logic [PAT_AW-1:0] win_word;
    logic [SUB_W-1:0]  win_sub;
    rgb_t              pal_rd;
    logic [WORD_W-1:0] pat_rd;
    logic [CODE_W-1:0] code;
    rgb_t              colour;
    logic              win_hit_q;

    cmix_window #(
        .COORD_W(COORD_W), .CUR_DIM(CUR_DIM), .PIX_PER_WORD(PIX_PER_WORD)
    ) u_window (
        .x(pix_x), .y(pix_y),
        .cx(cursor_pos[2*COORD_W-1:COORD_W]), .cy(cursor_pos[COORD_W-1:0]),
        .hide(cursor_off),
        .hit(win_hit), .word(win_word), .sub(win_sub)
    );

    cmix_ram #(.DEPTH(PAL_DEPTH), .WIDTH(RGB_W)) u_palette (
        .clk(clk), .we(pal_we), .waddr(pal_addr), .wdata(pal_data),
        .raddr(pix_index), .rdata(pal_rd)
    );

    cmix_ram #(.DEPTH(PAT_WORDS), .WIDTH(WORD_W)) u_pattern (
        .clk(clk), .we(pat_we), .waddr(pat_addr), .wdata(pat_data),
        .raddr(win_word), .rdata(pat_rd)
    );

    always_comb begin
        st_d = st_q;

        // stage 1: window decision travels alongside the RAM reads
        st_d.s1_valid = pix_valid;
        st_d.s1_hit   = pix_valid && win_hit;
        st_d.s1_sub   = win_sub;
        st_d.s1_blank = force_blank;

        for (int i = 0; i < CPAL_N; i++) begin
            if (cpal_we && (int'(cpal_sel) == i)) st_d.cpal[i] = cpal_data;
        end

        // stage 2: pick the code, then the colour
        code   = pat_rd[int'(st_q.s1_sub) * CODE_W +: CODE_W];
        colour = pal_rd;
        if (st_q.s1_hit && (code != '0)) begin
            colour = st_q.cpal[int'(code) - 1];
        end

        st_d.o_valid = st_q.s1_valid;
        st_d.o_rgb   = (st_q.s1_valid && !st_q.s1_blank) ? colour : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.o_valid;
    assign out_rgb   = st_q.o_rgb;
    assign win_hit_q = st_q.s1_hit;
endmodule

// File: rtl/cmix_checker.sv
module cmix_checker #(
    parameter int COORD_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_valid,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] cur_x,
    input logic               cursor_off,
    input logic               force_blank,
    input logic               win_hit_q,
    input logic               out_valid,
    input logic [23:0]        out_rgb
);
    a_r1_idle_black: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_rgb == '0));

    a_r2_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> ##2 out_valid);

    a_r2_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> ##2 !out_valid);

    a_r8_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && force_blank) |-> ##2 (out_rgb == '0));

    a_r7_hidden_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && cursor_off) |=> !win_hit_q);

    a_r9_left_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && (pix_x < cur_x)) |=> !win_hit_q);
endmodule

bind cursor_mixer cmix_checker #(.COORD_W(COORD_W)) u_cmix_checker (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x),
    .cur_x(cursor_pos[2*COORD_W-1:COORD_W]), .cursor_off(cursor_off),
    .force_blank(force_blank), .win_hit_q(win_hit_q),
    .out_valid(out_valid), .out_rgb(out_rgb)
);

// File: tb/test_cursor_mixer.sv
module test_cursor_mixer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pix_valid;
    logic [11:0] pix_x, pix_y;
    logic [7:0]  pix_index;
    logic [23:0] cursor_pos;
    logic        cursor_off, force_blank;
    logic        pal_we;
    logic [7:0]  pal_addr;
    logic [23:0] pal_data;
    logic        cpal_we;
    logic [1:0]  cpal_sel;
    logic [23:0] cpal_data;
    logic        pat_we;
    logic [8:0]  pat_addr;
    logic [15:0] pat_data;
    logic        out_valid;
    logic [23:0] out_rgb;

    int checks = 0;
    int failures = 0;
    string req = "R1";

    // behavioural model state
    int m_pal [256];
    int m_pat [512];
    int m_cpal [3];
    bit p_v = 0;
    int p_rgb = 0;

    always #2 clk = ~clk;

    cursor_mixer i_cursor_mixer (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x),
        .pix_y(pix_y), .pix_index(pix_index), .cursor_pos(cursor_pos),
        .cursor_off(cursor_off), .force_blank(force_blank),
        .pal_we(pal_we), .pal_addr(pal_addr), .pal_data(pal_data),
        .cpal_we(cpal_we), .cpal_sel(cpal_sel), .cpal_data(cpal_data),
        .pat_we(pat_we), .pat_addr(pat_addr), .pat_data(pat_data),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    function automatic int expect_rgb();
        int cx = int'(cursor_pos[23:12]);
        int cy = int'(cursor_pos[11:0]);
        int dx = int'(pix_x) - cx;
        int dy = int'(pix_y) - cy;
        if (force_blank) return 0;
        if (!cursor_off && dx >= 0 && dx < 64 && dy >= 0 && dy < 64) begin
            int w = m_pat[dy * 8 + dx / 8];
            int c = (w >> ((dx % 8) * 2)) & 3;
            if (c != 0) return m_cpal[c - 1];
        end
        return m_pal[pix_index];
    endfunction

    task automatic compare(bit ev, int ergb);
        checks++;
        if (out_valid !== ev || int'(out_rgb) !== ergb) begin
            failures++;
            $display("FAIL %s actual valid=%0b rgb=%06h expected valid=%0b rgb=%06h",
                     req, out_valid, out_rgb, ev, ergb[23:0]);
        end
    endtask

    // one clock: predict from current inputs, update model, compare after the edge
    task automatic tick();
        bit e_v = pix_valid;
        int e_rgb = pix_valid ? expect_rgb() : 0;
        if (pal_we) m_pal[pal_addr] = int'(pal_data);
        if (pat_we) m_pat[pat_addr] = int'(pat_data);
        if (cpal_we && cpal_sel < 3) m_cpal[cpal_sel] = int'(cpal_data);
        @(negedge clk);
        compare(p_v, p_rgb);
        p_v = e_v;
        p_rgb = e_rgb;
    endtask

    task automatic idle_inputs();
        pix_valid = 0; pal_we = 0; cpal_we = 0; pat_we = 0;
    endtask

    task automatic pixel(int x, int y, bit v);
        idle_inputs();
        pix_valid = v;
        pix_x = 12'(x); pix_y = 12'(y);
        pix_index = 8'(x * 7 + y * 3);
        tick();
    endtask

    task automatic scan(int x0, int x1, int y0, int y1, bit gaps);
        for (int y = y0; y <= y1; y++)
            for (int x = x0; x <= x1; x++)
                pixel(x & 12'hfff, y & 12'hfff, gaps ? ((x + y) % 3 != 0) : 1'b1);
        idle_inputs();
        tick(); tick();
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 0;
        idle_inputs();
        pix_x = 0; pix_y = 0; pix_index = 0; cursor_pos = 0;
        cursor_off = 0; force_blank = 0;
        pal_addr = 0; pal_data = 0; cpal_sel = 0; cpal_data = 0;
        pat_addr = 0; pat_data = 0;
        for (int i = 0; i < 3; i++) m_cpal[i] = 0;
        repeat (4) @(negedge clk);
        req = "R1";
        compare(1'b0, 0);
        rst_n = 1;

        // R1: cursor colours start at zero after reset
        req = "R1";
        cursor_pos = {12'd0, 12'd0};
        pix_valid = 1; pix_x = 0; pix_y = 0; pix_index = 0;
        for (int i = 0; i < 512; i++) m_pat[i] = 16'hffff;
        tick();
        idle_inputs(); tick(); tick();

        // load tables
        req = "R10";
        for (int i = 0; i < 256; i++) begin
            idle_inputs(); pal_we = 1; pal_addr = 8'(i);
            pal_data = {8'(i), 8'(~i), 8'(i ^ 8'h5a)};
            tick();
        end
        for (int i = 0; i < 512; i++) begin
            idle_inputs(); pat_we = 1; pat_addr = 9'(i);
            pat_data = 16'((i * 40503) ^ (i << 5) ^ 16'h3c01);
            tick();
        end
        for (int i = 0; i < 3; i++) begin
            idle_inputs(); cpal_we = 1; cpal_sel = 2'(i);
            cpal_data = 24'h101010 * (i + 3) + 24'h00000f;
            tick();
        end
        idle_inputs(); tick();

        // R3: colour table alone
        req = "R3";
        cursor_pos = {12'd2000, 12'd2000};
        scan(0, 99, 5, 6, 0);

        // R4 R5 R6: frame around the cursor square
        req = "R4 R5 R6";
        cursor_pos = {12'd100, 12'd50};
        scan(96, 167, 48, 115, 0);

        // R7: cursor hidden
        req = "R7";
        cursor_off = 1;
        scan(96, 167, 48, 60, 0);
        cursor_off = 0;

        // R8: forced black
        req = "R8";
        force_blank = 1;
        scan(96, 167, 48, 60, 0);
        force_blank = 0;

        // R2: gaps in the valid strobe
        req = "R2";
        scan(96, 167, 60, 70, 1);

        // R9: cursor near the far corner, scan crosses 4095 into 0
        req = "R9";
        cursor_pos = {12'd4070, 12'd4080};
        scan(4060, 4095, 4075, 4095, 0);
        scan(0, 20, 4075, 4085, 0);
        scan(4060, 4095, 0, 10, 0);
        cursor_pos = {12'd0, 12'd0};
        scan(0, 70, 0, 3, 0);

        // R10: writes seen by the pixel on the next cycle
        req = "R10";
        cursor_pos = {12'd2000, 12'd2000};
        idle_inputs(); pal_we = 1; pal_addr = 8'(10 * 7 + 4 * 3);
        pal_data = 24'habcdef; tick();
        pixel(10, 4, 1);
        cursor_pos = {12'd8, 12'd4};
        idle_inputs(); pat_we = 1; pat_addr = 9'd0; pat_data = 16'h00e4; tick();
        for (int x = 8; x < 12; x++) pixel(x, 4, 1);
        idle_inputs(); cpal_we = 1; cpal_sel = 2'd1; cpal_data = 24'h123456; tick();
        pixel(10, 4, 1);
        idle_inputs(); tick(); tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule